// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block is an integer address unit that keeps four independent buffer contexts. Each context holds a pointer, a base, a length and an update-mode setting. A caller issues a post-modify access by naming a context and giving a signed modifier. One cycle later the unit presents the pointer value that was current when the access was accepted. The stored pointer is advanced at that same point. In circular mode the advance wraps inside the buffer, which may start and end at any address. A length of zero gives plain linear stepping. A reverse-carry mode produces bit-reversed address sequences for FFT-style data reordering.

The stored pointer is rewritten one cycle after an access is accepted. A second access to the same context in the very next cycle would therefore read a stale value. The unit detects this case and raises `stall` until the update has landed. Contexts are set up through a simple register-write port.

Top module: `circ_agu`

## Requirements
- R1: Each of the four contexts is written through `cfg_we`/`cfg_ctx`/`cfg_fld`/`cfg_data`, and a write to one context never changes another. The field codes are 0 = pointer, 1 = base, 2 = length and 3 = control. In the control field, bit 0 enables reverse-carry mode and bits 5:1 give the reverse width in bits. A width above 16 is treated as 16.
- R2: After a synchronous reset, every context field is zero, and `addr_valid` and `stall` are both low.
- R3: A request is accepted in a cycle where `req_valid` is high and `stall` is low. In the following cycle `addr_valid` is high for exactly one cycle, and `addr` equals the context's pointer value before the update.
- R4: In circular mode (length ≠ 0, reverse off), a non-negative modifier that takes the pointer to base+length or beyond gives a new pointer of pointer+modifier−length.
- R5: In circular mode, a negative modifier that takes the pointer below base gives a new pointer of pointer+modifier+length.
- R6: When length = 0 and reverse mode is off, the new pointer is pointer+modifier modulo 2^16, with no wrap to a buffer.
- R7: In reverse-carry mode with width n, the low n bits of the pointer are added to the low n bits of the modifier, with the carry running from bit n−1 down toward bit 0. Bits above n keep their value. Base and length are ignored in this mode.
- R8: A request to the same context as the request accepted in the previous cycle sees `stall` high for exactly one cycle. A request to a different context sees no stall.
- R9: A stalled request is not issued. It is issued once `stall` drops, and it uses the updated pointer. Each accepted request yields exactly one output address.
- R10: A configuration write takes effect for a request accepted in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctx | input | 2 | Context selected for the write |
| cfg_fld | input | 2 | Field code (0 pointer, 1 base, 2 length, 3 control) |
| cfg_data | input | 16 | Write data |
| req_valid | input | 1 | Access request |
| req_ctx | input | 2 | Context used by the access |
| req_mod | input | 16 | Signed modifier, two's complement |
| stall | output | 1 | Request held back by a pending pointer update |
| addr_valid | output | 1 | `addr` carries an issued address |
| addr | output | 16 | Address before the post-modify update |

## Verification
Circular stepping is tried with a positive stride that wraps at the top and a negative stride that wraps at the base. Strides equal to ± the length show the inclusive/exclusive bound handling. A zero-length context stepped across 0xFFFF separates the linear mode from circular mode. A stride-8 reverse-carry walk over four bits with nonzero upper bits confirms that the carry runs backwards and that the upper bits are left alone. Back-to-back requests to the same context are compared with interleaved requests to all four contexts. This shows that stalls depend only on a real dependency, and that each stalled request still resolves to the updated pointer.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

    localparam int AW = 16;
    localparam int RW = $clog2(AW) + 1;

    typedef logic [AW-1:0]        addr_t;
    typedef logic signed [AW-1:0] mod_t;
    typedef logic [RW-1:0]        rwid_t;

    typedef enum logic [1:0] {
        FLD_PTR  = 2'd0,
        FLD_BASE = 2'd1,
        FLD_LEN  = 2'd2,
        FLD_CTL  = 2'd3
    } fld_e;

    typedef struct packed {
        addr_t ptr;
        addr_t base;
        addr_t len;
        logic  rev_en;
        rwid_t rev_w;
    } ctx_t;

    // mirror the low n bits of x; bits at or above n become zero
    function automatic addr_t rev_low(addr_t x, rwid_t n);
        addr_t r;
        r = '0;
        for (int i = 0; i < AW; i++) begin
            if (i < int'(n)) r[i] = x[int'(n) - 1 - i];
        end
        return r;
    endfunction

    function automatic addr_t low_mask(rwid_t n);
        addr_t m;
        for (int i = 0; i < AW; i++) m[i] = (i < int'(n));
        return m;
    endfunction

    function automatic rwid_t clamp_w(addr_t d);
        rwid_t w;
        w = d[RW:1];
        return (int'(w) > AW) ? rwid_t'(AW) : w;
    endfunction

endpackage

// File: rtl/cbuf_ctx_file.sv
module cbuf_ctx_file
    import cbuf_pkg::*;
#(
    parameter int NCTX = 4,
    localparam int CW = $clog2(NCTX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_ctx,
    input  logic [1:0]    cfg_fld,
    input  addr_t         cfg_data,
    input  logic          wb_en,
    input  logic [CW-1:0] wb_ctx,
    input  addr_t         wb_ptr,
    input  logic [CW-1:0] rd_ctx,
    output ctx_t          rd
);

    ctx_t regs [NCTX];

    for (genvar g = 0; g < NCTX; g++) begin : g_ctx
        logic sel_cfg;
        logic sel_wb;
        assign sel_cfg = cfg_we && (cfg_ctx == CW'(g));
        assign sel_wb  = wb_en  && (wb_ctx  == CW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else begin
                if (sel_cfg && fld_e'(cfg_fld) == FLD_PTR) regs[g].ptr <= cfg_data;
                else if (sel_wb)                           regs[g].ptr <= wb_ptr;
                if (sel_cfg && fld_e'(cfg_fld) == FLD_BASE) regs[g].base <= cfg_data;
                if (sel_cfg && fld_e'(cfg_fld) == FLD_LEN)  regs[g].len  <= cfg_data;
                if (sel_cfg && fld_e'(cfg_fld) == FLD_CTL) begin
                    regs[g].rev_en <= cfg_data[0];
                    regs[g].rev_w  <= clamp_w(cfg_data);
                end
            end
        end
    end

    assign rd = regs[rd_ctx];

endmodule

// File: rtl/cbuf_step.sv
module cbuf_step
    import cbuf_pkg::*;
(
    input  ctx_t  cur,
    input  mod_t  mod,
    output addr_t nxt
);

    localparam int XW = AW + 2;

    logic signed [XW-1:0] p_x, b_x, l_x, m_x, sum_x, end_x;
    addr_t rp, rm, rs, rlow, keep;

    always_comb begin
        p_x   = signed'({2'b00, cur.ptr});
        b_x   = signed'({2'b00, cur.base});
        l_x   = signed'({2'b00, cur.len});
        m_x   = signed'({{2{mod[AW-1]}}, mod});
        sum_x = p_x + m_x;
        end_x = b_x + l_x;

        rp   = rev_low(cur.ptr, cur.rev_w);
        rm   = rev_low(addr_t'(mod), cur.rev_w);
        rs   = rp + rm;
        rlow = rev_low(rs, cur.rev_w);
        keep = low_mask(cur.rev_w);

        if (cur.rev_en)
            nxt = (cur.ptr & ~keep) | (rlow & keep);
        else if (cur.len == '0)
            nxt = cur.ptr + addr_t'(mod);
        else if (!mod[AW-1] && sum_x >= end_x)
            nxt = addr_t'(sum_x - l_x);
        else if (mod[AW-1] && sum_x < b_x)
            nxt = addr_t'(sum_x + l_x);
        else
            nxt = addr_t'(sum_x);
    end

endmodule

// File: rtl/cbuf_hazard.sv
module cbuf_hazard #(
    parameter int NCTX = 4,
    localparam int CW = $clog2(NCTX)
) (
    input  logic          req_valid,
    input  logic [CW-1:0] req_ctx,
    input  logic          pend_v,
    input  logic [CW-1:0] pend_ctx,
    output logic          stall
);

    assign stall = req_valid && pend_v && (pend_ctx == req_ctx);

endmodule

// File: rtl/circ_agu.sv
module circ_agu
    import cbuf_pkg::*;
#(
    parameter int NCTX = 4,
    localparam int CW = $clog2(NCTX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_ctx,
    input  logic [1:0]    cfg_fld,
    input  logic [AW-1:0] cfg_data,
    input  logic          req_valid,
    input  logic [CW-1:0] req_ctx,
    input  logic [AW-1:0] req_mod,
    output logic          stall,
    output logic          addr_valid,
    output logic [AW-1:0] addr
);

    ctx_t          rd_ctx;
    logic          s1_v;
    logic [CW-1:0] s1_ctx;
    ctx_t          s1_c;
    mod_t          s1_mod;
    addr_t         nxt_ptr;
    logic          accept;

    assign accept = req_valid && !stall;

    cbuf_hazard #(.NCTX(NCTX)) u_haz (
        .req_valid (req_valid),
        .req_ctx   (req_ctx),
        .pend_v    (s1_v),
        .pend_ctx  (s1_ctx),
        .stall     (stall)
    );

    cbuf_ctx_file #(.NCTX(NCTX)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_ctx  (cfg_ctx),
        .cfg_fld  (cfg_fld),
        .cfg_data (cfg_data),
        .wb_en    (s1_v),
        .wb_ctx   (s1_ctx),
        .wb_ptr   (nxt_ptr),
        .rd_ctx   (req_ctx),
        .rd       (rd_ctx)
    );

    cbuf_step u_step (
        .cur (s1_c),
        .mod (s1_mod),
        .nxt (nxt_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v   <= 1'b0;
            s1_ctx <= '0;
            s1_c   <= '0;
            s1_mod <= '0;
        end else begin
            s1_v <= accept;
            if (accept) begin
                s1_ctx <= req_ctx;
                s1_c   <= rd_ctx;
                s1_mod <= mod_t'(req_mod);
            end
        end
    end

    assign addr_valid = s1_v;
    assign addr       = s1_c.ptr;

    // helper terms for the wrap check
    logic [AW:0] chk_ptr, chk_lo, chk_hi, chk_nxt, chk_mag;
    logic        chk_circ;
    assign chk_ptr  = {1'b0, s1_c.ptr};
    assign chk_lo   = {1'b0, s1_c.base};
    assign chk_hi   = {1'b0, s1_c.base} + {1'b0, s1_c.len};
    assign chk_nxt  = {1'b0, nxt_ptr};
    assign chk_mag  = s1_mod[AW-1] ? {1'b0, -s1_mod} : {1'b0, s1_mod};
    assign chk_circ = s1_v && !s1_c.rev_en && (s1_c.len != '0)
                      && (chk_ptr >= chk_lo) && (chk_ptr < chk_hi)
                      && (chk_mag <= {1'b0, s1_c.len});

    assert_wrap_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        chk_circ |-> (chk_nxt >= chk_lo && chk_nxt < chk_hi));

    assert_issue_follows_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !stall) |=> addr_valid);

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !stall) |=> !addr_valid);

    assert_stall_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
        stall |-> req_valid);

    assert_no_back_to_back_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !stall) |=> !(req_valid && !stall && req_ctx == $past(req_ctx)));

endmodule

// File: tb/sim_circ_agu.sv
`timescale 1ns/1ps
module sim_circ_agu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ctx = '0;
    logic [1:0]  cfg_fld = '0;
    logic [15:0] cfg_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_ctx = '0;
    logic [15:0] req_mod = '0;
    logic        stall, addr_valid;
    logic [15:0] addr;

    always #2.5 clk = ~clk;

    circ_agu u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ctx(cfg_ctx),
        .cfg_fld(cfg_fld), .cfg_data(cfg_data), .req_valid(req_valid),
        .req_ctx(req_ctx), .req_mod(req_mod), .stall(stall),
        .addr_valid(addr_valid), .addr(addr)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    int m_ptr[4], m_base[4], m_len[4], m_ren[4], m_rw[4];
    bit last_ok = 0;
    int last_ctx = 0;

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int model_next(int c, int m);
        int p, s, r, carry, bsum, n;
        p = m_ptr[c];
        if (m_ren[c] != 0) begin
            n = m_rw[c];
            r = p;
            carry = 0;
            for (int i = n - 1; i >= 0; i--) begin
                bsum = ((p >> i) & 1) + ((m >> i) & 1) + carry;
                r = (r & ~(1 << i)) | ((bsum & 1) << i);
                carry = bsum >> 1;
            end
            return r & 16'hFFFF;
        end
        s = p + m;
        if (m_len[c] != 0) begin
            if (m >= 0 && s >= m_base[c] + m_len[c]) s = s - m_len[c];
            else if (m < 0 && s < m_base[c]) s = s + m_len[c];
        end
        return s & 16'hFFFF;
    endfunction

    task automatic cfg(int c, int f, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ctx = 2'(c); cfg_fld = 2'(f); cfg_data = 16'(d);
        @(posedge clk);
        #1 cfg_we = 1'b0;
        case (f)
            0: m_ptr[c] = d & 16'hFFFF;
            1: m_base[c] = d & 16'hFFFF;
            2: m_len[c] = d & 16'hFFFF;
            default: begin
                m_ren[c] = d & 1;
                m_rw[c] = (d >> 1) & 31;
                if (m_rw[c] > 16) m_rw[c] = 16;
            end
        endcase
        last_ok = 0;
    endtask

    task automatic do_req(int c, int m, string req);
        int stalls = 0;
        int exp_st;
        @(negedge clk);
        req_valid = 1'b1; req_ctx = 2'(c); req_mod = 16'(m);
        exp_st = (last_ok && last_ctx == c) ? 1 : 0;
        #1;
        while (stall && stalls < 8) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        check(stalls == exp_st, "R8 stall cycles", stalls, exp_st);
        exp_q.push_back(16'(m_ptr[c]));
        tag_q.push_back(req);
        m_ptr[c] = model_next(c, m);
        last_ok = 1;
        last_ctx = c;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        last_ok = 0;
    endtask

    // monitor: pops expected addresses as the unit issues them
    always @(negedge clk) begin
        if (!rst && addr_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R9 unexpected issue", addr, 0);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(addr == e, t, addr, e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_ptr[i] = 0; m_base[i] = 0; m_len[i] = 0; m_ren[i] = 0; m_rw[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(addr_valid == 1'b0, "R2 addr_valid after reset", addr_valid, 0);
        check(stall == 1'b0, "R2 stall after reset", stall, 0);

        // R2: reset pointer is zero in linear mode
        do_req(0, 1, "R2 reset pointer");
        idle(2);

        // R4: positive stride wrapping at the top, back-to-back
        cfg(0, 1, 100); cfg(0, 2, 10); cfg(0, 0, 100);
        for (int k = 0; k < 6; k++) do_req(0, 3, "R4 positive wrap");
        // R4 bound: stride equal to the length keeps the pointer
        do_req(0, 10, "R4 stride equals length");
        do_req(0, -10, "R5 stride equals minus length");
        do_req(0, 0, "R4 after full stride");

        // R5: negative stride wrapping at the base
        cfg(1, 1, 200); cfg(1, 2, 7); cfg(1, 0, 206);
        for (int k = 0; k < 5; k++) do_req(1, -4, "R5 negative wrap");

        // R6: zero length, linear across 0xFFFF
        cfg(2, 0, 16'hFFFE);
        for (int k = 0; k < 3; k++) do_req(2, 3, "R6 linear step");

        // R7: reverse carry, width 4, upper bits set
        cfg(3, 1, 16'h0040); cfg(3, 2, 5);
        cfg(3, 3, (4 << 1) | 1); cfg(3, 0, 16'h0100);
        for (int k = 0; k < 9; k++) do_req(3, 8, "R7 reverse carry");

        // R1/R8: interleaved contexts, no stalls, no crosstalk
        for (int k = 0; k < 3; k++) begin
            do_req(0, 3, "R1 ctx0 interleaved");
            do_req(1, -4, "R1 ctx1 interleaved");
            do_req(2, 5, "R1 ctx2 interleaved");
            do_req(3, 8, "R1 ctx3 interleaved");
        end

        // R10: a write is seen by the request right behind it
        cfg(2, 0, 16'h0500);
        do_req(2, 1, "R10 write then access");
        do_req(2, 1, "R9 stalled access uses update");

        // R1: clamp a width above the field size
        cfg(1, 3, (31 << 1) | 1); cfg(1, 0, 16'h0000);
        for (int k = 0; k < 3; k++) do_req(1, 16'h8000, "R1 width clamp");

        idle(4);
        check(exp_q.size() == 0, "R3 all issued", exp_q.size(), 0);
        finish_run();
    end

endmodule